// File: doc/BRIEF.md
# Voltage-Setting Code Slew Controller

This block sits between a register that holds a requested output-voltage setting and the resistor-ladder D/A converter that produces the converter's reference. The request is a 5-bit code, where code 0 gives the lowest setting (0.725 V) and code 31 gives the highest (1.5 V). A new request is never passed straight to the ladder. The block keeps its own active code and moves it one step at a time toward the request. It makes one step on each tick of a tracking clock, which comes from dividing the system clock by a programmable ratio. That ratio therefore sets how fast the reference rises and falls.

While the active code is moving, the block drives a force-PWM signal so that the converter regulates with fixed-frequency pulses and does not skip any. A busy output carries the same level. When the active code reaches the request, it holds there. Force-PWM then stays high until the following tracking tick, which gives the loop one extra tick to settle.

A four-state machine controls the motion:
- IDLE: the code equals the request and force-PWM is low.
- RISE: the code steps up on each tick.
- FALL: the code steps down on each tick.
- SETTLE: the last step has landed on the request.

Transitions:
- IDLE goes to RISE or FALL one clock after the request becomes different from the active code.
- On a tick, RISE and FALL keep stepping.
- On the tick that lands on the request, RISE or FALL goes to SETTLE.
- On a tick in SETTLE, the machine returns to IDLE if the code still matches. Otherwise it redirects to RISE or FALL.
- On a tick in RISE or FALL, a new request that equals the current code sends the machine straight to IDLE.

Top module: `dvs_ref_slewer`

## Requirements
- R1: After reset, and after any reset applied during a move, code_out is 0 and force_pwm and busy are 0.
- R2: A request is captured from tgt_data on a clock edge where tgt_wr is 1. code_out never changes by more than one per change, and it never wraps between 0 and 31.
- R3: code_out counts up while the request is above it and down while the request is below it, and it stops exactly at the request. Ending at 31 or at 0 holds without wrap.
- R4: Within one move, consecutive steps of code_out are exactly rate_div+1 clock cycles apart. code_out changes only on a tracking tick.
- R5: If a request written at clock edge E differs from code_out, force_pwm is 1 after edge E+1. It stays 1 for as long as code_out differs from the captured request.
- R6: After the step that makes code_out equal to the request, code_out holds, and force_pwm falls exactly rate_div+1 clock cycles after that step.
- R7: A request written during a move redirects the count from the current value with no reset. The next step is one code from the value the count had reached, toward the new request.
- R8: busy always equals force_pwm.
- R9: A request equal to code_out, written while idle, leaves code_out unchanged and force_pwm at 0. While force_pwm is 0, code_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_div | input | DIV_W (8) | Tracking tick period minus one, in system clock cycles |
| tgt_wr | input | 1 | Request write strobe |
| tgt_data | input | CODE_W (5) | Requested voltage-setting code |
| code_out | output | CODE_W (5) | Active code driving the resistor-ladder D/A |
| force_pwm | output | 1 | Holds the converter in fixed-frequency PWM while moving |
| busy | output | 1 | Copy of force_pwm |

## Verification
The bench tries the block with several kinds of move:
- Full-range rises and falls (0 to 31, 31 to 0). These tell correct saturation-free counting apart from wrap at the ends.
- Short moves of one or a few codes at several divider ratios. These separate the step spacing (rate_div+1) from the settle delay before force-PWM drops.
- A write of the current value. This shows that a no-op request causes no motion and no force-PWM pulse.
- A request changed during a move. This distinguishes redirection from the reached value from a restart at an old value.
- A reset during a move. This confirms that the outputs return to their reset levels.

// File: rtl/dvs_slew_pkg.sv
package dvs_slew_pkg;
    typedef enum logic [1:0] {
        TRK_IDLE   = 2'd0,
        TRK_RISE   = 2'd1,
        TRK_FALL   = 2'd2,
        TRK_SETTLE = 2'd3
    } trk_state_e;
endpackage

// File: rtl/dvs_rate_tick.sv
// Free-running divider: one-cycle tick every rate_div+1 clocks.
module dvs_rate_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // >= so that lowering rate_div below the running count ends the period at once
    assign tick = (cnt_q >= rate_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dvs_step_counter.sv
// Up/down counter for the active code, saturating at both ends.
module dvs_step_counter #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;
    assign code = code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (step_up && !step_dn && code_q != CODE_MAX) begin
            code_q <= code_q + 1'b1;
        end else if (step_dn && !step_up && code_q != '0) begin
            code_q <= code_q - 1'b1;
        end
    end
endmodule

// File: rtl/dvs_track_fsm.sv
// Decides direction, when to step and when force-PWM may drop.
module dvs_track_fsm
    import dvs_slew_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] tgt,
    input  logic [CODE_W-1:0] code,
    output logic              step_up,
    output logic              step_dn,
    output logic              force_pwm
);
    trk_state_e state_q, state_d;
    logic [CODE_W-1:0] code_inc, code_dec;
    logic              above, below;

    assign code_inc = code + 1'b1;
    assign code_dec = code - 1'b1;
    assign above    = (tgt > code);
    assign below    = (tgt < code);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (above) begin
                    state_d = TRK_RISE;
                end else if (below) begin
                    state_d = TRK_FALL;
                end
            end
            TRK_RISE, TRK_FALL, TRK_SETTLE: begin
                if (tick) begin
                    if (above) begin
                        state_d = (code_inc == tgt) ? TRK_SETTLE : TRK_RISE;
                    end else if (below) begin
                        state_d = (code_dec == tgt) ? TRK_SETTLE : TRK_FALL;
                    end else begin
                        state_d = TRK_IDLE;
                    end
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        step_up   = 1'b0;
        step_dn   = 1'b0;
        force_pwm = 1'b0;
        unique case (state_q)
            TRK_IDLE: begin
                force_pwm = 1'b0;
            end
            TRK_RISE, TRK_FALL, TRK_SETTLE: begin
                force_pwm = 1'b1;
                step_up   = tick && above;
                step_dn   = tick && below;
            end
            default: force_pwm = 1'b0;
        endcase
    end
endmodule

// File: rtl/dvs_ref_slewer.sv
module dvs_ref_slewer #(
    parameter int CODE_W = 5,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              tgt_wr,
    input  logic [CODE_W-1:0] tgt_data,
    output logic [CODE_W-1:0] code_out,
    output logic              force_pwm,
    output logic              busy
);
    logic [CODE_W-1:0] tgt_q;
    logic              tick;
    logic              step_up, step_dn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (tgt_wr) begin
            tgt_q <= tgt_data;
        end
    end

    dvs_rate_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_div (rate_div),
        .tick     (tick)
    );

    dvs_track_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tgt       (tgt_q),
        .code      (code_out),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .force_pwm (force_pwm)
    );

    dvs_step_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (step_up),
        .step_dn (step_dn),
        .code    (code_out)
    );

    assign busy = force_pwm;
endmodule

// File: rtl/dvs_ref_slewer_chk.sv
module dvs_ref_slewer_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CODE_W-1:0] tgt_q,
    input logic [CODE_W-1:0] code_out,
    input logic              force_pwm,
    input logic              busy
);
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |->
        ((code_out > $past(code_out)) ? (code_out - $past(code_out) == 1)
                                      : ($past(code_out) - code_out == 1)));

    p_up_only_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out > $past(code_out)) |-> ($past(tgt_q) > $past(code_out)));

    p_down_only_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out < $past(code_out)) |-> ($past(tgt_q) < $past(code_out)));

    p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |-> $past(tick));

    p_fpwm_when_diff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_out != tgt_q) && $past(code_out != tgt_q)) |-> force_pwm);

    p_busy_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == force_pwm);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(force_pwm) |-> (code_out == $past(code_out)));
endmodule

bind dvs_ref_slewer dvs_ref_slewer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tgt_q     (tgt_q),
    .code_out  (code_out),
    .force_pwm (force_pwm),
    .busy      (busy)
);

// File: tb/tb_dvs_ref_slewer.sv
`timescale 1ns/1ps
module tb_dvs_ref_slewer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rate_div = 8'd0;
    logic       tgt_wr = 1'b0;
    logic [4:0] tgt_data = 5'd0;
    logic [4:0] code_out;
    logic       force_pwm;
    logic       busy;

    always #2.5 clk = ~clk;

    dvs_ref_slewer dut (
        .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .tgt_wr(tgt_wr),
        .tgt_data(tgt_data), .code_out(code_out), .force_pwm(force_pwm), .busy(busy)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    int   cyc = 0;
    logic [4:0] prev_code = 5'd0;
    logic prev_fp = 1'b0;
    int   ups, dns, nsteps, last_step_cyc, fall_cyc, min_gap, max_gap;
    bit   ever_fp, jump_seen, mirror_bad;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_code = code_out;
            prev_fp   = force_pwm;
        end else begin
            cyc++;
            if (busy !== force_pwm) mirror_bad = 1'b1;
            if (force_pwm) ever_fp = 1'b1;
            if (code_out != prev_code) begin
                if (code_out > prev_code) begin
                    ups++;
                    if (code_out - prev_code != 1) jump_seen = 1'b1;
                end else begin
                    dns++;
                    if (prev_code - code_out != 1) jump_seen = 1'b1;
                end
                if (nsteps > 0) begin
                    if (cyc - last_step_cyc < min_gap) min_gap = cyc - last_step_cyc;
                    if (cyc - last_step_cyc > max_gap) max_gap = cyc - last_step_cyc;
                end
                nsteps++;
                last_step_cyc = cyc;
            end
            if (prev_fp && !force_pwm) fall_cyc = cyc;
            prev_code = code_out;
            prev_fp   = force_pwm;
        end
    end

    task automatic clear_mon();
        ups = 0; dns = 0; nsteps = 0; last_step_cyc = 0; fall_cyc = -1;
        min_gap = 1000000; max_gap = 0; ever_fp = 1'b0; jump_seen = 1'b0;
    endtask

    task automatic write_tgt(input logic [4:0] v);
        tgt_wr = 1'b1; tgt_data = v;
        @(negedge clk); #1;
        tgt_wr = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk); #1;
            if (!force_pwm) break;
        end
    endtask

    task automatic run_move(input int div, input logic [4:0] tgt);
        logic [4:0] start;
        @(negedge clk); #1;
        rate_div = div[7:0];
        clear_mon();
        start = code_out;
        write_tgt(tgt);              // captured at edge E
        @(negedge clk); #1;          // after edge E+1
        check(force_pwm == (tgt != start), (tgt != start) ? "R5 fpwm raised" : "R9 no fpwm",
              force_pwm, tgt != start);
        wait_idle(40 * (div + 2) + 20);
        #1;
        check(code_out == tgt, "R3 final code", code_out, tgt);
        if (tgt > start) begin
            check(ups == tgt - start && dns == 0, "R3 up count", ups, tgt - start);
        end else if (tgt < start) begin
            check(dns == start - tgt && ups == 0, "R3 down count", dns, start - tgt);
        end else begin
            check(nsteps == 0 && !ever_fp, "R9 no motion", nsteps, 0);
        end
        check(!jump_seen, "R2 single steps", jump_seen, 0);
        if (nsteps >= 2) begin
            check(min_gap == div + 1 && max_gap == div + 1, "R4 step spacing", max_gap, div + 1);
        end
        if (nsteps >= 1) begin
            check(fall_cyc - last_step_cyc == div + 1, "R6 settle delay",
                  fall_cyc - last_step_cyc, div + 1);
        end
        check(!mirror_bad, "R8 busy mirror", mirror_bad, 0);
    endtask

    typedef struct packed { logic [7:0] div; logic [4:0] tgt; } vec_t;
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0, 5'd31}, '{8'd3, 5'd0},  '{8'd1, 5'd17}, '{8'd2, 5'd5},
        '{8'd0, 5'd5},  '{8'd5, 5'd6},  '{8'd4, 5'd31}, '{8'd7, 5'd30},
        '{8'd2, 5'd31}, '{8'd0, 5'd0}
    };

    initial begin
        mirror_bad = 1'b0;
        clear_mon();
        repeat (3) @(negedge clk);
        #1;
        check(code_out == 0 && !force_pwm && !busy, "R1 reset state", code_out, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(code_out == 0 && !force_pwm, "R1 idle after reset", code_out, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_move(VECS[i].div, VECS[i].tgt);
        end

        // R7: redirect mid-move from the value reached
        @(negedge clk); #1;
        rate_div = 8'd3;
        write_tgt(5'd20);
        for (int i = 0; i < 200; i++) begin
            if (code_out == 5'd5) break;
            @(negedge clk); #1;
        end
        check(code_out == 5'd5, "R7 reached midpoint", code_out, 5);
        write_tgt(5'd2);
        for (int i = 0; i < 50; i++) begin
            if (code_out != 5'd5) break;
            @(negedge clk); #1;
        end
        check(code_out == 5'd4, "R7 redirect step", code_out, 4);
        wait_idle(200);
        check(code_out == 5'd2, "R7 final code", code_out, 2);

        // R1: reset during a move
        @(negedge clk); #1;
        rate_div = 8'd0;
        write_tgt(5'd31);
        repeat (6) @(negedge clk);
        #1;
        check(force_pwm == 1'b1, "R5 moving before reset", force_pwm, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(code_out == 0 && !force_pwm && !busy, "R1 reset mid move", code_out, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check(code_out == 0 && !force_pwm, "R1 stays after reset", code_out, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule